// File: doc/BRIEF.md
# Dual-Input Page Program Receiver

This block is the slave-side front end of a serial flash for one command: a page program whose data arrives two bits per serial clock. It samples chip select, the serial clock and two data pins with the system clock, then finds the serial clock's rising edges. It decodes an 8-bit opcode and a 24-bit start address, both sent one bit per clock on the single input pin. It then assembles data bytes from pairs of bits and stores them in a 256-byte page buffer.

Writes into the buffer start at the low address byte and wrap within the page. Each stored byte sets its bit in a written mask. When chip select is released after a complete address, the block raises a one-cycle program request. The request carries the page number, the start offset, the saturated byte count, the buffer and the mask. The command runs only while the write enable latch is set, and the request clears that latch.

Top module: `dual_pgm_rx`

## Requirements
- R1: After reset `wel` is 0, `prog_req` is 0, `prog_mask` is all zero and `prog_count` is 0.
- R2: A one-cycle pulse on `wel_set` makes `wel` read 1 from the next clock. `wel` returns to 0 in the same cycle that `prog_req` is high.
- R3: Bits are sampled on serial clock rising edges while `cs_n` is low, and the opcode is shifted MSB first on `si`. The command is accepted only if the opcode equals 8'hA2 and `wel` is 1 when its eighth bit arrives. Otherwise the transaction raises no request and leaves `prog_data` and `prog_mask` unchanged.
- R4: The 24 address bits follow on `si`, MSB first. On the request, `prog_page` equals address bits 23..8 and `prog_start` equals address bits 7..0.
- R5: Each data clock carries two bits of a byte, MSB first. `soi` carries the higher bit of each pair and `si` the lower one. A byte is complete after four rising edges, and byte offset i of the page is shown at `prog_data[8*i+7:8*i]`.
- R6: The first data byte goes to offset `prog_start`. Each following byte goes to the next offset, and offset 8'hFF is followed by 8'h00 of the same page.
- R7: When more than 256 bytes are sent, the buffer holds the last 256 bytes sent and `prog_count` saturates at 256.
- R8: On every accepted command the buffer is reset so that all bytes read 8'hFF and all mask bits read 0. Offsets that receive no byte stay at 8'hFF with mask bit 0.
- R9: A data byte that is not complete when `cs_n` rises is discarded. It changes neither the buffer, the mask nor the count.
- R10: If `cs_n` rises before all 24 address bits are in, no request is raised and `wel` stays set.
- R11: `prog_req` is a single-cycle pulse, high in the third clock after `cs_n` rises at the pin. It is raised only for an accepted command whose address is complete, even if no data byte followed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wel_set | input | 1 | Pulse that sets the write enable latch |
| cs_n | input | 1 | Serial chip select, active low |
| sclk | input | 1 | Serial clock, idle low |
| si | input | 1 | Serial input; opcode, address and low bit of each data pair |
| soi | input | 1 | Second serial input; high bit of each data pair |
| wel | output | 1 | Write enable latch state |
| prog_req | output | 1 | One-cycle program request |
| prog_page | output | 16 | Page number of the request |
| prog_start | output | 8 | Start offset within the page |
| prog_count | output | 9 | Bytes received, saturated at 256 |
| prog_data | output | 2048 | Page buffer, byte i at bits 8i+7..8i |
| prog_mask | output | 256 | Written mask, bit i for byte i |

## Verification
A start offset of FEh with three bytes exercises the wrap. A design that failed to wrap would drop the third byte or place it in a neighbour page's offset. A 300-byte burst checks that the oldest bytes are overwritten and that the count stops at 256; a design that got this wrong would show the first bytes or a count above 256. Further transactions use a wrong opcode, a cleared latch, chip select released mid-address, and a trailing partial byte. Wrong handling of these would show up as a spurious request, a lost latch, or a stray byte or mask bit. Back-to-back commands show whether the mask and buffer are reset, since a stale design would carry the first command's bytes into the second request.

// File: rtl/dual_pgm_rx_pkg.sv
package dual_pgm_rx_pkg;

  localparam int PAGE_BYTES = 256;
  localparam int IDX_W      = $clog2(PAGE_BYTES);
  localparam int CNT_W      = IDX_W + 1;
  localparam int ADDR_W     = 24;
  localparam int OPC_W      = 8;
  localparam logic [OPC_W-1:0] OPC_DUAL_PGM = 8'hA2;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_OPC,
    ST_ADDR,
    ST_DATA,
    ST_SKIP
  } rx_state_e;

  // Push one bit pair into a byte shifter, higher bit first.
  function automatic logic [7:0] f_pair_shift(input logic [7:0] sh,
                                              input logic hi,
                                              input logic lo);
    return {sh[5:0], hi, lo};
  endfunction

  // Next byte offset inside the page; wraps naturally at the width.
  function automatic logic [IDX_W-1:0] f_wrap_inc(input logic [IDX_W-1:0] idx);
    return idx + 1'b1;
  endfunction

  // Byte count that stops at one full page.
  function automatic logic [CNT_W-1:0] f_sat_inc(input logic [CNT_W-1:0] cnt);
    return (cnt >= CNT_W'(PAGE_BYTES)) ? cnt : cnt + 1'b1;
  endfunction

endpackage

// File: rtl/dpr_sync.sv
module dpr_sync #(
  parameter int          W     = 4,
  parameter logic [W-1:0] RST_V = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  for (genvar g = 0; g < W; g++) begin : g_bit
    logic s1, s2;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        s1 <= RST_V[g];
        s2 <= RST_V[g];
      end else begin
        s1 <= d[g];
        s2 <= s1;
      end
    end
    assign q[g] = s2;
  end
endmodule

// File: rtl/dpr_ctrl.sv
module dpr_ctrl
  import dual_pgm_rx_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wel_set,
  input  logic              cs_n_s,
  input  logic              sclk_s,
  input  logic              si_s,
  input  logic              soi_s,
  output logic              wel,
  output logic              prog_req,
  output logic [15:0]       page,
  output logic [IDX_W-1:0]  start,
  output logic [CNT_W-1:0]  count,
  output logic              wr_en,
  output logic [IDX_W-1:0]  wr_idx,
  output logic [7:0]        wr_byte,
  output logic              accept_evt,
  output logic              in_data
);
  rx_state_e            state;
  logic                 cs_prev, sck_prev;
  logic [4:0]           bit_cnt;
  logic [ADDR_W-1:0]    sh;
  logic [ADDR_W-1:0]    sh_nxt;
  logic [1:0]           pair_cnt;
  logic [7:0]           dsh;
  logic [IDX_W-1:0]     idx;

  logic cs_rise, cs_fall, sck_rise, quiet;
  assign cs_rise  = cs_n_s & ~cs_prev;
  assign cs_fall  = ~cs_n_s & cs_prev;
  assign sck_rise = sclk_s & ~sck_prev & ~cs_n_s;
  assign quiet    = ~cs_rise & ~cs_fall;
  assign sh_nxt   = {sh[ADDR_W-2:0], si_s};

  assign accept_evt = quiet && sck_rise && state == ST_OPC && bit_cnt == 5'd7 &&
                      sh_nxt[OPC_W-1:0] == OPC_DUAL_PGM && wel;
  assign wr_en      = quiet && sck_rise && state == ST_DATA && pair_cnt == 2'd3;
  assign wr_idx     = idx;
  assign wr_byte    = f_pair_shift(dsh, soi_s, si_s);
  assign in_data    = state == ST_DATA;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      cs_prev  <= 1'b1;
      sck_prev <= 1'b0;
      bit_cnt  <= '0;
      sh       <= '0;
      pair_cnt <= '0;
      dsh      <= '0;
      idx      <= '0;
      wel      <= 1'b0;
      prog_req <= 1'b0;
      page     <= '0;
      start    <= '0;
      count    <= '0;
    end else begin
      cs_prev  <= cs_n_s;
      sck_prev <= sclk_s;
      prog_req <= 1'b0;
      if (wel_set) wel <= 1'b1;
      if (cs_rise) begin
        state <= ST_IDLE;
        if (state == ST_DATA) begin
          prog_req <= 1'b1;
          wel      <= 1'b0;
        end
      end else if (cs_fall) begin
        state   <= ST_OPC;
        bit_cnt <= '0;
      end else if (sck_rise) begin
        unique case (state)
          ST_OPC: begin
            sh <= sh_nxt;
            if (bit_cnt == 5'd7) begin
              bit_cnt <= '0;
              state   <= accept_evt ? ST_ADDR : ST_SKIP;
            end else begin
              bit_cnt <= bit_cnt + 1'b1;
            end
          end
          ST_ADDR: begin
            sh <= sh_nxt;
            if (bit_cnt == 5'd23) begin
              state    <= ST_DATA;
              page     <= sh_nxt[23:8];
              start    <= sh_nxt[7:0];
              idx      <= sh_nxt[7:0];
              count    <= '0;
              pair_cnt <= '0;
            end else begin
              bit_cnt <= bit_cnt + 1'b1;
            end
          end
          ST_DATA: begin
            dsh      <= wr_byte;
            pair_cnt <= pair_cnt + 1'b1;
            if (wr_en) begin
              idx   <= f_wrap_inc(idx);
              count <= f_sat_inc(count);
            end
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/dpr_pagebuf.sv
module dpr_pagebuf
  import dual_pgm_rx_pkg::*;
(
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    clr,
  input  logic                    wr_en,
  input  logic [IDX_W-1:0]        wr_idx,
  input  logic [7:0]              wr_byte,
  output logic [PAGE_BYTES*8-1:0] data,
  output logic [PAGE_BYTES-1:0]   mask
);
  for (genvar i = 0; i < PAGE_BYTES; i++) begin : g_byte
    logic hit;
    assign hit = wr_en && wr_idx == IDX_W'(i);
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        data[8*i +: 8] <= 8'hFF;
        mask[i]        <= 1'b0;
      end else if (clr) begin
        data[8*i +: 8] <= 8'hFF;
        mask[i]        <= 1'b0;
      end else if (hit) begin
        data[8*i +: 8] <= wr_byte;
        mask[i]        <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/dual_pgm_rx.sv
module dual_pgm_rx
  import dual_pgm_rx_pkg::*;
(
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    wel_set,
  input  logic                    cs_n,
  input  logic                    sclk,
  input  logic                    si,
  input  logic                    soi,
  output logic                    wel,
  output logic                    prog_req,
  output logic [15:0]             prog_page,
  output logic [IDX_W-1:0]        prog_start,
  output logic [CNT_W-1:0]        prog_count,
  output logic [PAGE_BYTES*8-1:0] prog_data,
  output logic [PAGE_BYTES-1:0]   prog_mask
);
  logic [3:0]       pins_s;
  logic             wr_en, accept_evt, in_data;
  logic [IDX_W-1:0] wr_idx;
  logic [7:0]       wr_byte;

  dpr_sync #(.W(4), .RST_V(4'b0001)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     ({soi, si, sclk, cs_n}),
    .q     (pins_s)
  );

  dpr_ctrl u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .wel_set    (wel_set),
    .cs_n_s     (pins_s[0]),
    .sclk_s     (pins_s[1]),
    .si_s       (pins_s[2]),
    .soi_s      (pins_s[3]),
    .wel        (wel),
    .prog_req   (prog_req),
    .page       (prog_page),
    .start      (prog_start),
    .count      (prog_count),
    .wr_en      (wr_en),
    .wr_idx     (wr_idx),
    .wr_byte    (wr_byte),
    .accept_evt (accept_evt),
    .in_data    (in_data)
  );

  dpr_pagebuf u_buf (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr     (accept_evt),
    .wr_en   (wr_en),
    .wr_idx  (wr_idx),
    .wr_byte (wr_byte),
    .data    (prog_data),
    .mask    (prog_mask)
  );
endmodule

// File: rtl/dual_pgm_rx_chk.sv
module dual_pgm_rx_chk
  import dual_pgm_rx_pkg::*;
(
  input logic                  clk,
  input logic                  rst_n,
  input logic                  wel,
  input logic                  prog_req,
  input logic [CNT_W-1:0]      prog_count,
  input logic [PAGE_BYTES-1:0] prog_mask,
  input logic                  accept_evt,
  input logic                  wr_en,
  input logic [IDX_W-1:0]      wr_idx,
  input logic                  in_data
);
  // R2: the request always leaves the latch cleared
  a_r2_wel_cleared: assert property (@(posedge clk) disable iff (!rst_n)
    prog_req |-> !wel);

  // R3: a request needs the latch set in the cycle before
  a_r3_req_needs_wel: assert property (@(posedge clk) disable iff (!rst_n)
    prog_req |-> $past(wel));

  // R6: offset FFh is followed by offset 00h
  a_r6_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_idx == '1) |=> wr_idx == '0);

  // R7: the count never exceeds one page
  a_r7_count_sat: assert property (@(posedge clk) disable iff (!rst_n)
    prog_count <= CNT_W'(PAGE_BYTES));

  // R8: accepting a command empties the mask
  a_r8_mask_cleared: assert property (@(posedge clk) disable iff (!rst_n)
    accept_evt |=> prog_mask == '0);

  // R11: a request only follows the data phase, and lasts one cycle
  a_r11_req_after_data: assert property (@(posedge clk) disable iff (!rst_n)
    prog_req |-> $past(in_data));
  a_r11_req_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    prog_req |=> !prog_req);
endmodule

bind dual_pgm_rx dual_pgm_rx_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .wel        (wel),
  .prog_req   (prog_req),
  .prog_count (prog_count),
  .prog_mask  (prog_mask),
  .accept_evt (accept_evt),
  .wr_en      (wr_en),
  .wr_idx     (wr_idx),
  .in_data    (in_data)
);

// File: tb/dual_pgm_rx_bench.sv
`timescale 1ns/1ps
module dual_pgm_rx_bench;
  logic clk = 1'b0, rst_n = 1'b0;
  logic wel_set = 1'b0, cs_n = 1'b1, sclk = 1'b0, si = 1'b0, soi = 1'b0;
  logic        wel, prog_req;
  logic [15:0] prog_page;
  logic [7:0]  prog_start;
  logic [8:0]  prog_count;
  logic [2047:0] prog_data;
  logic [255:0]  prog_mask;

  always #2 clk = ~clk;

  dual_pgm_rx u_dual_pgm_rx (.*);

  int checks = 0, failures = 0;
  int cyc = 0;
  int req_due = -1, wel_due = -1;
  bit exp_wel = 1'b0;
  bit mon_on = 1'b0;
  bit done = 1'b0;
  byte unsigned m_buf[256];
  bit           m_msk[256];
  int m_page, m_start, m_count;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic check_buf(input string req);
    int bad = 0;
    int first = -1;
    for (int i = 0; i < 256; i++)
      if (prog_data[8*i +: 8] != m_buf[i] || prog_mask[i] != m_msk[i]) begin
        bad++;
        if (first < 0) first = i;
      end
    if (first < 0) check(1'b1, req, "buffer", 0, 0);
    else check(1'b0, req, "buffer byte", {prog_mask[first], prog_data[8*first +: 8]},
               {m_msk[first], m_buf[first]});
  endtask

  // Per-clock comparison against the behavioural model
  always @(negedge clk) begin
    if (mon_on) begin
      if (cyc == wel_due) exp_wel = 1'b1;
      if (cyc == req_due) exp_wel = 1'b0;
      check(prog_req == (cyc == req_due), "R11", "prog_req", prog_req, cyc == req_due);
      check(wel == exp_wel, "R2", "wel", wel, exp_wel);
      if (cyc == req_due) begin
        check(prog_page == m_page[15:0], "R4", "page", prog_page, m_page);
        check(prog_start == m_start[7:0], "R4", "start", prog_start, m_start);
        check(prog_count == m_count[8:0], "R7", "count", prog_count, m_count);
        check_buf("R5");
      end
    end
  end

  always @(posedge clk)
    if (cyc > 150000 && !done) begin
      done = 1'b1;
      failures++;
      checks++;
      $display("FAIL watchdog actual=%0d expected=<150000", cyc);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse(input bit hi, input bit lo);
    soi = hi;
    si  = lo;
    wait_clk(3);
    sclk = 1'b1;
    wait_clk(3);
    sclk = 1'b0;
  endtask

  task automatic set_wel;
    @(negedge clk);
    wel_set = 1'b1;
    wel_due = cyc + 1;
    @(negedge clk);
    wel_set = 1'b0;
    wait_clk(2);
  endtask

  // opc, address, full bytes, pattern seed, trailing pairs, address bits sent
  task automatic run_cmd(input logic [7:0] opc, input logic [23:0] adr, input int n,
                         input int seed, input int tail, input int abits);
    bit acc;
    int pos;
    acc = (opc == 8'hA2) && exp_wel;
    @(negedge clk);
    cs_n = 1'b0;
    wait_clk(3);
    for (int b = 7; b >= 0; b--) pulse(1'b0, opc[b]);
    if (acc) begin
      for (int i = 0; i < 256; i++) begin m_buf[i] = 8'hFF; m_msk[i] = 1'b0; end
    end
    for (int b = 23; b >= 24 - abits; b--) pulse(1'b0, adr[b]);
    if (abits == 24) begin
      pos = adr[7:0];
      for (int k = 0; k < n; k++) begin
        logic [7:0] v;
        v = 8'((seed + k * 37) ^ (k >> 3));
        for (int p = 3; p >= 0; p--) pulse(v[2*p+1], v[2*p]);
        if (acc) begin
          m_buf[pos] = v;
          m_msk[pos] = 1'b1;
          pos = (pos + 1) % 256;
        end
      end
      for (int p = 0; p < tail; p++) pulse(1'b1, 1'b0);
    end
    wait_clk(4);
    cs_n = 1'b1;
    if (acc && abits == 24) begin
      m_page  = adr[23:8];
      m_start = adr[7:0];
      m_count = (n > 256) ? 256 : n;
      req_due = cyc + 3;
    end
    wait_clk(8);
  endtask

  initial begin
    for (int i = 0; i < 256; i++) begin m_buf[i] = 8'hFF; m_msk[i] = 1'b0; end
    wait_clk(3);
    rst_n = 1'b1;
    wait_clk(1);
    // R1: reset state
    check(wel == 1'b0, "R1", "wel", wel, 0);
    check(prog_req == 1'b0, "R1", "prog_req", prog_req, 0);
    check(prog_mask == '0, "R1", "mask", prog_mask[31:0], 0);
    check(prog_count == 9'd0, "R1", "count", prog_count, 0);
    mon_on = 1'b1;

    // R3: latch clear, command ignored
    run_cmd(8'hA2, 24'h012300, 2, 8'h11, 0, 24);
    check_buf("R3");
    // R2 R4 R5 R8: plain command
    set_wel();
    run_cmd(8'hA2, 24'h3A5C10, 5, 8'h5A, 0, 24);
    // R3: wrong opcode leaves buffer untouched
    set_wel();
    run_cmd(8'h02, 24'h000000, 3, 8'h77, 0, 24);
    check_buf("R3");
    // R10: chip select released mid-address keeps latch, no request
    run_cmd(8'hA2, 24'h00FF00, 0, 0, 0, 12);
    check(wel == 1'b1, "R10", "wel", wel, 1);
    // R6: wrap from FEh
    run_cmd(8'hA2, 24'h0000FE, 3, 8'hC3, 0, 24);
    check(prog_data[7:0] != 8'hFF && prog_mask[0], "R6", "byte0 mask", prog_mask[0], 1);
    // R9: partial trailing byte discarded
    set_wel();
    run_cmd(8'hA2, 24'h112280, 2, 8'h3C, 3, 24);
    check(prog_mask[8'h82] == 1'b0, "R9", "mask 82h", prog_mask[8'h82], 0);
    // R8: second command resets buffer, zero bytes still requests
    set_wel();
    run_cmd(8'hA2, 24'h112240, 0, 0, 0, 24);
    check(prog_mask == '0, "R8", "mask", prog_mask[31:0], 0);
    // R7: overflow, last 256 kept
    set_wel();
    run_cmd(8'hA2, 24'h7F0010, 300, 8'h21, 0, 24);
    check_buf("R7");

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule